// File: doc/BRIEF.md
# Shadow Memory Store/Recall Controller

This block keeps a small volatile byte array next to an equally sized nonvolatile shadow array, one shadow byte for each volatile byte. A host reads and writes the volatile array through a synchronous port. A save request copies the volatile bytes into the shadow, and a restore request brings the shadow bytes back into the volatile array. Each transfer runs in two phases. A save first erases the shadow and then programs it. A restore first clears the volatile array and then copies the shadow into it. A busy output shows when a transfer is running. While it is high, host accesses and new requests are ignored.

Two supply-status inputs model the power monitor. When the supply drops below the reset level, a power-loss flag is latched. Once the supply is no longer below the reset level and is above the switch level again, the latched flag starts an automatic restore. A supply dip that never reaches the reset level latches nothing. If the host is still writing when the automatic restore ends, a sticky corruption flag is raised.

Top module: `sms_ctrl`

## Requirements
- R1: When busy is low, a write with wr_en stores wdata at addr. A read with rd_en presents the byte at addr on rdata one clock after the request.
- R2: An accepted store_req erases every shadow byte to 8'hFF for ERASE_CYC cycles. It then programs one address per cycle, from address 0 up to the last, with the volatile data. Busy stays high for exactly ERASE_CYC+DEPTH cycles, starting in the cycle after acceptance.
- R3: An accepted recall_req clears every volatile byte to 0 for CLEAR_CYC cycles. It then copies one shadow byte per cycle into the volatile array. Busy stays high for exactly CLEAR_CYC+DEPTH cycles.
- R4: A restore never changes the shadow contents, so repeated restores return the same data each time.
- R5: While busy is high, host writes do not change the volatile array, and rdata holds its last value.
- R6: A store_req or recall_req that arrives while busy is high is ignored and is not queued.
- R7: vcc_below_reset high latches a power-loss flag. When the flag is set, vcc_below_reset is low and vcc_above_switch is high, an automatic restore starts, with the same timing as R3. Starting it clears the flag.
- R8: A drop of vcc_above_switch without vcc_below_reset ever going high starts no restore.
- R9: If wr_en is high in the final copy cycle of an automatic restore, corrupt goes high and stays high. The start of the next automatic restore clears it.
- R10: Reset clears busy, the power-loss flag, corrupt and rdata. It leaves the shadow array unchanged.
- R11: When both requests arrive in the same idle cycle, the store wins. A pending automatic restore takes precedence over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | ADDR_W | Host byte address |
| wdata | input | DATA_W | Host write data |
| rdata | output | DATA_W | Registered read data |
| store_req | input | 1 | Request a copy from volatile to shadow |
| recall_req | input | 1 | Request a copy from shadow to volatile |
| vcc_below_reset | input | 1 | Supply is under the reset level |
| vcc_above_switch | input | 1 | Supply is above the switch level |
| busy | output | 1 | A transfer is running |
| corrupt | output | 1 | A write overlapped the end of an automatic restore |

## Verification
The bench counts the busy cycles of each transfer kind and of simultaneous requests, which exposes an off-by-one phase counter or the wrong request priority. It writes and reads during a save to show that a leaky busy gate would corrupt data or move rdata. It also shows that a request made while busy must not be queued. Supply sequences check three cases: a design that latched on a shallow dip would run a spurious restore, one that ignored the switch level would restore too early, and one whose reset failed to clear the flag would restore after reset. A write held across the end of an automatic restore must raise corrupt, and a clean restore afterwards must clear it.

// File: rtl/sms_pkg.sv
package sms_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ERASE,
        PH_PROG,
        PH_CLEAR,
        PH_COPY
    } phase_e;

    typedef enum logic [1:0] {
        JOB_NONE,
        JOB_SAVE,
        JOB_RESTORE,
        JOB_AUTO
    } job_e;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    // automatic restore beats save, save beats restore
    function automatic job_e pick_job(input logic auto_i, input logic save_i,
                                      input logic rest_i);
        if (auto_i)      return JOB_AUTO;
        else if (save_i) return JOB_SAVE;
        else if (rest_i) return JOB_RESTORE;
        else             return JOB_NONE;
    endfunction

endpackage

// File: rtl/sms_pwr.sv
module sms_pwr (
    input  logic clk,
    input  logic rst,
    input  logic below_reset,
    input  logic above_switch,
    input  logic take,
    output logic trig
);
    logic lost_q;

    always_ff @(posedge clk) begin
        if (rst)              lost_q <= 1'b0;
        else if (below_reset) lost_q <= 1'b1;
        else if (take)        lost_q <= 1'b0;
    end

    assign trig = lost_q && !below_reset && above_switch;

    assert_latch_set_R7: assert property (@(posedge clk) disable iff (rst)
        below_reset |=> lost_q);
    assert_no_shallow_latch_R8: assert property (@(posedge clk) disable iff (rst)
        (!lost_q && !below_reset) |=> !lost_q);

endmodule

// File: rtl/sms_seq.sv
module sms_seq
    import sms_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int ERASE_CYC = 3,
    parameter int CLEAR_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              auto_req,
    input  logic              save_req,
    input  logic              rest_req,
    output phase_e            phase,
    output logic [ADDR_W-1:0] idx,
    output logic              busy,
    output logic              auto_run,
    output logic              last_copy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int MAXC  = (DEPTH > ERASE_CYC) ?
                           ((DEPTH > CLEAR_CYC) ? DEPTH : CLEAR_CYC) :
                           ((ERASE_CYC > CLEAR_CYC) ? ERASE_CYC : CLEAR_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);

    localparam logic [CNT_W-1:0] ERASE_END = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] CLEAR_END = CNT_W'(CLEAR_CYC - 1);
    localparam logic [CNT_W-1:0] SWEEP_END = CNT_W'(DEPTH - 1);

    phase_e           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic             auto_q;
    job_e             job;

    assign job = pick_job(auto_req, save_req, rest_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            auto_q <= 1'b0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    case (job)
                        JOB_AUTO:    begin ph_q <= PH_CLEAR; auto_q <= 1'b1; end
                        JOB_SAVE:    ph_q <= PH_ERASE;
                        JOB_RESTORE: begin ph_q <= PH_CLEAR; auto_q <= 1'b0; end
                        default:     ph_q <= PH_IDLE;
                    endcase
                end
                PH_ERASE: begin
                    if (cnt_q == ERASE_END) begin ph_q <= PH_PROG; cnt_q <= '0; end
                    else cnt_q <= cnt_q + 1'b1;
                end
                PH_PROG: begin
                    if (cnt_q == SWEEP_END) begin ph_q <= PH_IDLE; cnt_q <= '0; end
                    else cnt_q <= cnt_q + 1'b1;
                end
                PH_CLEAR: begin
                    if (cnt_q == CLEAR_END) begin ph_q <= PH_COPY; cnt_q <= '0; end
                    else cnt_q <= cnt_q + 1'b1;
                end
                PH_COPY: begin
                    if (cnt_q == SWEEP_END) begin
                        ph_q   <= PH_IDLE;
                        cnt_q  <= '0;
                        auto_q <= 1'b0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign phase     = ph_q;
    assign idx       = cnt_q[ADDR_W-1:0];
    assign busy      = (ph_q != PH_IDLE);
    assign auto_run  = auto_q;
    assign last_copy = (ph_q == PH_COPY) && (cnt_q == SWEEP_END);

    assert_erase_then_prog_R2: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_ERASE) |=> (ph_q == PH_ERASE || ph_q == PH_PROG));
    assert_prog_ends_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_PROG && cnt_q == SWEEP_END) |=> (ph_q == PH_IDLE));
    assert_clear_then_copy_R3: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_CLEAR) |=> (ph_q == PH_CLEAR || ph_q == PH_COPY));
    assert_busy_ignores_req_R6: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_PROG && cnt_q != SWEEP_END) |=> (ph_q == PH_PROG));

endmodule

// File: rtl/sms_mem.sv
module sms_mem
    import sms_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic [ADDR_W-1:0] idx,
    input  logic              busy,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] ERASED = DATA_W'(ERASED_BYTE);

    logic [DATA_W-1:0] vol_q [DEPTH];
    logic [DATA_W-1:0] shd_q [DEPTH];

    always_ff @(posedge clk) begin
        if (phase == PH_CLEAR) begin
            for (int i = 0; i < DEPTH; i++) vol_q[i] <= '0;
        end else if (phase == PH_COPY) begin
            vol_q[idx] <= shd_q[idx];
        end else if (!busy && wr_en) begin
            vol_q[addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (phase == PH_ERASE) begin
            for (int i = 0; i < DEPTH; i++) shd_q[i] <= ERASED;
        end else if (phase == PH_PROG) begin
            shd_q[idx] <= vol_q[idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                rdata <= '0;
        else if (!busy && rd_en) rdata <= vol_q[addr];
    end

    assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(rdata));
    assert_restore_keeps_shadow_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CLEAR || phase == PH_COPY) |=> $stable(shd_q[0]));

endmodule

// File: rtl/sms_ctrl.sv
module sms_ctrl
    import sms_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int ERASE_CYC = 3,
    parameter int CLEAR_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              store_req,
    input  logic              recall_req,
    input  logic              vcc_below_reset,
    input  logic              vcc_above_switch,
    output logic              busy,
    output logic              corrupt
);
    phase_e            phase;
    logic [ADDR_W-1:0] idx;
    logic              trig, take, auto_run, last_copy, corrupt_q;

    assign take = trig && !busy;

    sms_pwr u_pwr (
        .clk          (clk),
        .rst          (rst),
        .below_reset  (vcc_below_reset),
        .above_switch (vcc_above_switch),
        .take         (take),
        .trig         (trig)
    );

    sms_seq #(.ADDR_W(ADDR_W), .ERASE_CYC(ERASE_CYC), .CLEAR_CYC(CLEAR_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .auto_req  (trig),
        .save_req  (store_req),
        .rest_req  (recall_req),
        .phase     (phase),
        .idx       (idx),
        .busy      (busy),
        .auto_run  (auto_run),
        .last_copy (last_copy)
    );

    sms_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .idx   (idx),
        .busy  (busy),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)                                 corrupt_q <= 1'b0;
        else if (take)                           corrupt_q <= 1'b0;
        else if (last_copy && auto_run && wr_en) corrupt_q <= 1'b1;
    end

    assign corrupt = corrupt_q;

    assert_corrupt_only_in_transfer_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(corrupt_q) |-> $past(busy));
    assert_auto_start_busy_R7: assert property (@(posedge clk) disable iff (rst)
        take |=> busy);

endmodule

// File: tb/sim_sms_ctrl.sv
`timescale 1ns/1ps
module sim_sms_ctrl;
    localparam int AW = 4, DW = 8, EC = 3, CC = 2;
    localparam int DEPTH = 1 << AW;
    localparam int SAVE_LEN = EC + DEPTH;
    localparam int REST_LEN = CC + DEPTH;

    // {addr, data}: write then read back
    localparam logic [11:0] VEC [0:7] = '{12'h0A5, 12'h15A, 12'h2FF, 12'h300,
                                           12'h7C3, 12'h93C, 12'hE81, 12'hF7E};

    logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
    logic [AW-1:0] addr = 0;
    logic [DW-1:0] wdata = 0, rdata;
    logic store_req = 0, recall_req = 0, vlow = 0, vok = 1, busy, corrupt;

    int tests = 0, fails = 0;
    bit done = 0;
    logic [DW-1:0] vol_m [DEPTH];
    logic [DW-1:0] shd_m [DEPTH];

    always #2.5 clk = ~clk;

    sms_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ERASE_CYC(EC), .CLEAR_CYC(CC)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .store_req(store_req), .recall_req(recall_req),
        .vcc_below_reset(vlow), .vcc_above_switch(vok), .busy(busy), .corrupt(corrupt));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1; addr = AW'(a); wdata = DW'(d);
        @(negedge clk); wr_en = 0;
        if (!busy) vol_m[a] = DW'(d);
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        rd_en = 1; addr = AW'(a);
        @(negedge clk); rd_en = 0; d = rdata;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy === 1'b1 && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic pulse(input bit s, input bit r, output int n);
        store_req = s; recall_req = r;
        @(negedge clk); store_req = 0; recall_req = 0;
        busy_len(n);
    endtask

    task automatic check_all(input string req);
        logic [DW-1:0] d;
        int bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            rd(i, d);
            if (d !== vol_m[i]) begin
                bad++;
                $display("FAIL %s addr %0d actual=%0h expected=%0h", req, i, d, vol_m[i]);
            end
        end
        tests++;
        if (bad != 0) fails++;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        int n;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(busy === 0 && corrupt === 0 && rdata === 0, "R10 reset outputs",
              {busy, corrupt, rdata}, 0);
        rst = 0;
        @(negedge clk);

        for (int i = 0; i < DEPTH; i++) wr(i, (i * 37 + 5) & 8'hFF);
        // R1 vector table
        for (int k = 0; k < 8; k++) begin
            wr(int'(VEC[k][11:8]), int'(VEC[k][7:0]));
            rd(int'(VEC[k][11:8]), d);
            check(d === VEC[k][7:0], "R1 write/read", d, VEC[k][7:0]);
        end
        check_all("R1 full readback");

        // R2 save length
        rd(5, d);
        store_req = 1;
        @(negedge clk); store_req = 0;
        for (int i = 0; i < DEPTH; i++) shd_m[i] = vol_m[i];
        // R5 write/read while busy, R6 request while busy
        n = 1;
        wr_en = 1; rd_en = 1; addr = 3; wdata = 8'h99; recall_req = 1;
        @(negedge clk); wr_en = 0; rd_en = 0; recall_req = 0; n++;
        check(rdata === vol_m[5], "R5 rdata held while busy", rdata, vol_m[5]);
        while (busy === 1'b1 && n < 1000) begin n++; @(negedge clk); end
        n = n - 1;
        check(n == SAVE_LEN, "R2 save busy cycles", n, SAVE_LEN);
        @(negedge clk);
        check(busy === 0, "R6 no queued restore", busy, 0);
        rd(3, d);
        check(d === vol_m[3], "R5 write ignored while busy", d, vol_m[3]);

        // R3 restore
        for (int i = 0; i < DEPTH; i++) wr(i, i ^ 8'h5A);
        pulse(0, 1, n);
        check(n == REST_LEN, "R3 restore busy cycles", n, REST_LEN);
        for (int i = 0; i < DEPTH; i++) vol_m[i] = shd_m[i];
        check_all("R3 restored data");
        // R4 repeated restore
        for (int i = 0; i < DEPTH; i++) wr(i, 8'hC3);
        pulse(0, 1, n);
        for (int i = 0; i < DEPTH; i++) vol_m[i] = shd_m[i];
        check_all("R4 second restore same data");

        // R11 simultaneous requests: save wins
        pulse(1, 1, n);
        check(n == SAVE_LEN, "R11 save wins", n, SAVE_LEN);

        // R8 shallow dip
        vok = 0; repeat (3) @(negedge clk); vok = 1;
        repeat (4) @(negedge clk);
        check(busy === 0, "R8 no restore after shallow dip", busy, 0);

        // R7 deep drop, waits for switch level
        for (int i = 0; i < DEPTH; i++) wr(i, 8'h11);
        vok = 0; vlow = 1; repeat (2) @(negedge clk); vlow = 0;
        repeat (3) @(negedge clk);
        check(busy === 0, "R7 waits for switch level", busy, 0);
        // R9: write held across end of automatic restore
        wr_en = 1; addr = 0; wdata = 8'h55; vok = 1;
        @(negedge clk);
        busy_len(n);
        wr_en = 0;
        check(n == REST_LEN, "R7 automatic restore cycles", n, REST_LEN);
        check(corrupt === 1, "R9 corrupt flagged", corrupt, 1);
        for (int i = 0; i < DEPTH; i++) vol_m[i] = shd_m[i];
        check_all("R7 automatic restore data");
        vlow = 1; @(negedge clk); vlow = 0; @(negedge clk);
        check(busy === 1 && corrupt === 0, "R9 corrupt cleared at next auto start",
              {busy, corrupt}, 2);
        busy_len(n);
        check(corrupt === 0, "R9 clean auto restore", corrupt, 0);

        // R10 reset clears latch, keeps shadow
        for (int i = 0; i < DEPTH; i++) wr(i, 8'hEE);
        vok = 0; vlow = 1; repeat (2) @(negedge clk); vlow = 0;
        rst = 1; repeat (2) @(negedge clk); rst = 0;
        check(rdata === 0 && corrupt === 0, "R10 reset clears rdata", rdata, 0);
        vok = 1; repeat (4) @(negedge clk);
        check(busy === 0, "R10 latch cleared by reset", busy, 0);
        pulse(0, 1, n);
        for (int i = 0; i < DEPTH; i++) vol_m[i] = shd_m[i];
        check_all("R10 shadow kept over reset");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule